// File: doc/BRIEF.md
# Sequenced Matrix Multiply Engine

This block multiplies two 8x8 matrices of 8-bit signed integers and keeps the 64 products in an on-block result store. All the arithmetic goes through one multiply-accumulate unit. An index sequencer walks the row, column and inner-product positions. For each output element it presents eight operand pairs to that unit. The first pair replaces the running sum and the other seven add to it.

Before a run, the host fills the two operand stores through a shared write port. The store address is row*8+col. A one-cycle start pulse then launches the run. Each output element is written back one cycle after its last accumulation, under the row and column indices held from the previous step. Outputs are produced across the columns of row 0, then row 1, and so on. A sticky done flag signals completion. A cycle counter reports how many clock edges the run took. After completion the host reads the results through an asynchronous read port.

Top module: `matmul_engine`

## Requirements
- R1: Asserting aLoadEn or bLoadEn for a clock edge writes loadData (8-bit signed) into operand A or B at element loadAddr = row*8+col. The write is accepted only when no run is in progress, meaning after reset or once done is high. Load writes during a run have no effect.
- R2: The multiply-accumulate unit replaces its sum with the product of its two signed operands on a clear step. On any other step it adds that product to the sum.
- R3: After a run, result element (i,j) equals the sum over k = 0..7 of A[i][k]*B[k][j] as a 19-bit signed value. This holds with no overflow over the full operand range, including +131072 when every operand is -128.
- R4: resAddr = i*8+j (values 0..63) reads result element (i,j) combinationally. Addresses 64 to 127 read as zero.
- R5: Each output element takes 8 cycles. It is written to the result store one cycle after its final accumulation. done rises on the 513th rising edge after the edge that samples start, and is low on the 512th.
- R6: Once high, done stays high until reset or a new start.
- R7: The edge that accepts start clears clockCount to 0. clockCount then increments once per edge while the run is in progress. It freezes at 513 when done rises.
- R8: A start pulse during a run is ignored: the counting, the completion time and the results are unchanged.
- R9: A start pulse while done is high relaunches the run. After that edge, done is low and clockCount is 0, and the new results reflect the current operands.
- R10: A synchronous active-high reset clears done and clockCount and aborts any run. The engine then stays idle until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| reset | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, sampled on a rising edge |
| aLoadEn | input | 1 | Write strobe for operand A |
| bLoadEn | input | 1 | Write strobe for operand B |
| loadAddr | input | 6 | Operand element address, row*8+col |
| loadData | input | 8 | Signed operand value to write |
| resAddr | input | 7 | Result read address, row*8+col |
| resData | output | 19 | Signed result at resAddr, zero for addresses 64 and above |
| done | output | 1 | High once all 64 results are stored |
| clockCount | output | 16 | Edges counted since the start edge, frozen at completion |

## Verification
Suppose the inner-product index or the clear strobe slips by one step. Every element then absorbs a neighbour's product or keeps a stale sum, and the mismatch shows in the first result read after done. Suppose the held write-back indices are wrong. Results then land at shifted addresses, which the identity-matrix test exposes element by element. A miscounted sequencer moves the done edge off 513 or changes the frozen count. The bench checks this on the exact edge, and the embedded properties catch a missed write strobe or a lost sum one cycle after it happens.

// File: rtl/mme_pkg.sv
package mme_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FLUSH,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic macEn;
    logic macClear;
    logic resWr;
  } dpStrobe_t;

endpackage

// File: rtl/mme_operand_bank.sv
module mme_operand_bank #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     wrEn,
  input  logic [AW-1:0]            wrAddr,
  input  logic signed [DATA_W-1:0] wrData,
  input  logic [AW-1:0]            rdAddr,
  output logic signed [DATA_W-1:0] rdData
);

  logic signed [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  assign rdData = mem[rdAddr];

endmodule

// File: rtl/mme_mac.sv
module mme_mac #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 19,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     enable,
  input  logic                     clear,
  input  logic signed [DATA_W-1:0] opA,
  input  logic signed [DATA_W-1:0] opB,
  output logic signed [ACC_W-1:0]  accum
);

  logic signed [PROD_W-1:0] product;
  logic signed [ACC_W-1:0]  prodExt;

  assign product = opA * opB;
  assign prodExt = {{(ACC_W - PROD_W){product[PROD_W-1]}}, product};

  always_ff @(posedge clk) begin
    if (enable) begin
      if (clear) accum <= prodExt;
      else       accum <= accum + prodExt;
    end
  end

  // R2: a clear step replaces the sum with the product
  a_r2_clear_loads: assert property (@(posedge clk) disable iff (rst)
    (enable && clear) |=> (accum == $past(prodExt)));

  // R2: a non-clear step adds the product to the sum
  a_r2_accumulate: assert property (@(posedge clk) disable iff (rst)
    (enable && !clear) |=> (accum == $past(accum) + $past(prodExt)));

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!enable) |=> $stable(accum));

endmodule

// File: rtl/mme_datapath.sv
module mme_datapath
  import mme_pkg::*;
#(
  parameter int DIM    = 8,
  parameter int DATA_W = 8,
  parameter int ACC_W  = 19,
  localparam int IDX_W   = $clog2(DIM),
  localparam int ELEM_AW = 2 * IDX_W,
  localparam int CELLS   = DIM * DIM,
  localparam int RES_AW  = ELEM_AW + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  dpStrobe_t                strobe,
  input  logic                     loadOk,
  input  logic                     aWrEn,
  input  logic                     bWrEn,
  input  logic [ELEM_AW-1:0]       ldAddr,
  input  logic signed [DATA_W-1:0] ldData,
  input  logic [IDX_W-1:0]         rowIdx,
  input  logic [IDX_W-1:0]         colIdx,
  input  logic [IDX_W-1:0]         kIdx,
  input  logic [IDX_W-1:0]         wrRow,
  input  logic [IDX_W-1:0]         wrCol,
  input  logic [RES_AW-1:0]        rdAddr,
  output logic signed [ACC_W-1:0]  rdData
);

  logic signed [DATA_W-1:0] aOperand;
  logic signed [DATA_W-1:0] bOperand;
  logic signed [ACC_W-1:0]  macSum;
  logic [ELEM_AW-1:0]       aRdAddr;
  logic [ELEM_AW-1:0]       bRdAddr;
  logic [ELEM_AW-1:0]       resWrAddr;

  // A walks along row i, B walks down column j
  assign aRdAddr   = {rowIdx, kIdx};
  assign bRdAddr   = {kIdx, colIdx};
  assign resWrAddr = {wrRow, wrCol};

  mme_operand_bank #(.DEPTH(CELLS), .DATA_W(DATA_W)) aBank (
    .clk   (clk),
    .wrEn  (aWrEn && loadOk),
    .wrAddr(ldAddr),
    .wrData(ldData),
    .rdAddr(aRdAddr),
    .rdData(aOperand)
  );

  mme_operand_bank #(.DEPTH(CELLS), .DATA_W(DATA_W)) bBank (
    .clk   (clk),
    .wrEn  (bWrEn && loadOk),
    .wrAddr(ldAddr),
    .wrData(ldData),
    .rdAddr(bRdAddr),
    .rdData(bOperand)
  );

  mme_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) macUnit (
    .clk   (clk),
    .rst   (rst),
    .enable(strobe.macEn),
    .clear (strobe.macClear),
    .opA   (aOperand),
    .opB   (bOperand),
    .accum (macSum)
  );

  logic signed [ACC_W-1:0] resMem [CELLS];

  always_ff @(posedge clk) begin
    if (strobe.resWr) resMem[resWrAddr] <= macSum;
  end

  assign rdData = rdAddr[RES_AW-1] ? '0 : resMem[rdAddr[ELEM_AW-1:0]];

  // R5: the multiplier is never mid-sum on a write-back cycle
  a_r5_no_accumulate_on_write: assert property (@(posedge clk) disable iff (rst)
    strobe.resWr |-> (!strobe.macEn || strobe.macClear));

endmodule

// File: rtl/mme_control.sv
module mme_control
  import mme_pkg::*;
#(
  parameter int DIM   = 8,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(DIM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output dpStrobe_t         strobe,
  output logic [IDX_W-1:0]  rowIdx,
  output logic [IDX_W-1:0]  colIdx,
  output logic [IDX_W-1:0]  kIdx,
  output logic [IDX_W-1:0]  wrRow,
  output logic [IDX_W-1:0]  wrCol,
  output logic              loadOk,
  output logic              done,
  output logic [CNT_W-1:0]  clockCount
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DIM - 1);

  seqState_t state;
  logic      wrPend;
  logic      busy;

  assign busy = (state == ST_RUN) || (state == ST_FLUSH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      rowIdx     <= '0;
      colIdx     <= '0;
      kIdx       <= '0;
      wrRow      <= '0;
      wrCol      <= '0;
      wrPend     <= 1'b0;
      clockCount <= '0;
    end else begin
      wrPend <= 1'b0;
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state      <= ST_RUN;
            rowIdx     <= '0;
            colIdx     <= '0;
            kIdx       <= '0;
            clockCount <= '0;
          end
        end
        ST_RUN: begin
          clockCount <= clockCount + CNT_W'(1);
          if (kIdx == LAST) begin
            wrPend <= 1'b1;
            wrRow  <= rowIdx;
            wrCol  <= colIdx;
            kIdx   <= '0;
            if (colIdx == LAST) begin
              colIdx <= '0;
              if (rowIdx == LAST) state <= ST_FLUSH;
              else                rowIdx <= rowIdx + IDX_W'(1);
            end else begin
              colIdx <= colIdx + IDX_W'(1);
            end
          end else begin
            kIdx <= kIdx + IDX_W'(1);
          end
        end
        ST_FLUSH: begin
          clockCount <= clockCount + CNT_W'(1);
          state      <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.macEn    = (state == ST_RUN);
    strobe.macClear = (kIdx == '0);
    strobe.resWr    = wrPend;
  end

  assign loadOk = !busy;
  assign done   = (state == ST_DONE);

  // R5: last inner step is followed by a result write
  a_r5_write_follows_last: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && kIdx == LAST) |=> strobe.resWr);

  // R6: done holds until a new start
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R7: counter frozen while done
  a_r7_count_frozen: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> $stable(clockCount));

  // R8: start during a run does not disturb counting
  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (clockCount == $past(clockCount) + CNT_W'(1)));

  // R9: start after completion relaunches from zero
  a_r9_relaunch: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> (!done && clockCount == '0));

  // R1: operand loading is closed during a run
  a_r1_load_closed_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !loadOk);

endmodule

// File: rtl/matmul_engine.sv
module matmul_engine
  import mme_pkg::*;
#(
  parameter int DIM    = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  localparam int IDX_W   = $clog2(DIM),
  localparam int ELEM_AW = 2 * IDX_W,
  localparam int RES_AW  = ELEM_AW + 1,
  localparam int ACC_W   = 2 * DATA_W + IDX_W
) (
  input  logic                     clk,
  input  logic                     reset,
  input  logic                     start,
  input  logic                     aLoadEn,
  input  logic                     bLoadEn,
  input  logic [ELEM_AW-1:0]       loadAddr,
  input  logic signed [DATA_W-1:0] loadData,
  input  logic [RES_AW-1:0]        resAddr,
  output logic signed [ACC_W-1:0]  resData,
  output logic                     done,
  output logic [CNT_W-1:0]         clockCount
);

  dpStrobe_t        strobe;
  logic [IDX_W-1:0] rowIdx;
  logic [IDX_W-1:0] colIdx;
  logic [IDX_W-1:0] kIdx;
  logic [IDX_W-1:0] wrRow;
  logic [IDX_W-1:0] wrCol;
  logic             loadOk;

  mme_control #(.DIM(DIM), .CNT_W(CNT_W)) ctrl (
    .clk       (clk),
    .rst       (reset),
    .start     (start),
    .strobe    (strobe),
    .rowIdx    (rowIdx),
    .colIdx    (colIdx),
    .kIdx      (kIdx),
    .wrRow     (wrRow),
    .wrCol     (wrCol),
    .loadOk    (loadOk),
    .done      (done),
    .clockCount(clockCount)
  );

  mme_datapath #(.DIM(DIM), .DATA_W(DATA_W), .ACC_W(ACC_W)) dp (
    .clk   (clk),
    .rst   (reset),
    .strobe(strobe),
    .loadOk(loadOk),
    .aWrEn (aLoadEn),
    .bWrEn (bLoadEn),
    .ldAddr(loadAddr),
    .ldData(loadData),
    .rowIdx(rowIdx),
    .colIdx(colIdx),
    .kIdx  (kIdx),
    .wrRow (wrRow),
    .wrCol (wrCol),
    .rdAddr(resAddr),
    .rdData(resData)
  );

endmodule

// File: tb/matmul_engine_test.sv
module matmul_engine_test;

  logic               clk = 1'b0;
  logic               reset = 1'b1;
  logic               start = 1'b0;
  logic               aLoadEn = 1'b0;
  logic               bLoadEn = 1'b0;
  logic [5:0]         loadAddr = '0;
  logic signed [7:0]  loadData = '0;
  logic [6:0]         resAddr = '0;
  logic signed [18:0] resData;
  logic               done;
  logic [15:0]        clockCount;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int refA [64];
  int refB [64];

  always #2 clk = ~clk;

  matmul_engine uut (
    .clk(clk), .reset(reset), .start(start),
    .aLoadEn(aLoadEn), .bLoadEn(bLoadEn),
    .loadAddr(loadAddr), .loadData(loadData),
    .resAddr(resAddr), .resData(resData),
    .done(done), .clockCount(clockCount)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL R5 watchdog: cycles=%0d expected below 150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic loadMats();
    for (int idx = 0; idx < 64; idx++) begin
      @(negedge clk);
      aLoadEn = 1'b1; loadAddr = 6'(idx); loadData = 8'(refA[idx]);
    end
    @(negedge clk); aLoadEn = 1'b0;
    for (int idx = 0; idx < 64; idx++) begin
      @(negedge clk);
      bLoadEn = 1'b1; loadAddr = 6'(idx); loadData = 8'(refB[idx]);
    end
    @(negedge clk); bLoadEn = 1'b0;
  endtask

  // R5/R7: done and count checked on the exact edges; interference at edge n (R8, R1)
  task automatic runTimed(input int interfereAt);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!done && clockCount == 0, "R9 cleared after start edge", int'(clockCount), 0);
    for (int n = 1; n <= 513; n++) begin
      if (n == interfereAt) begin
        start = 1'b1; aLoadEn = 1'b1; loadAddr = 6'd0; loadData = 8'(~refA[0]);
      end
      @(negedge clk);
      start = 1'b0; aLoadEn = 1'b0;
      if (n == 512) check(!done, "R5 done low at edge 512", int'(done), 0);
      if (n == 513) begin
        check(done, "R5 done high at edge 513", int'(done), 1);
        check(clockCount == 513, "R7 final count", int'(clockCount), 513);
      end
    end
  endtask

  task automatic checkResults(input string req);
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        int expv = 0;
        for (int k = 0; k < 8; k++) expv += refA[i*8+k] * refB[k*8+j];
        resAddr = 7'(i*8 + j);
        #1;
        check(int'(resData) == expv, req, int'(resData), expv);
      end
    end
  endtask

  task automatic t_reset();
    check(done == 1'b0, "R10 done after reset", int'(done), 0);
    check(clockCount == 0, "R10 count after reset", int'(clockCount), 0);
  endtask

  task automatic t_random();
    for (int idx = 0; idx < 64; idx++) begin
      refA[idx] = int'($urandom_range(255)) - 128;
      refB[idx] = int'($urandom_range(255)) - 128;
    end
    loadMats();
    runTimed(0);
    checkResults("R3 random product");
  endtask

  task automatic t_extremes();
    for (int idx = 0; idx < 64; idx++) begin refA[idx] = -128; refB[idx] = -128; end
    loadMats();
    runTimed(0);
    checkResults("R3 max positive 131072");
    for (int idx = 0; idx < 64; idx++) refB[idx] = 127;
    loadMats();
    runTimed(0);
    checkResults("R3 most negative");
  endtask

  task automatic t_identity();
    for (int idx = 0; idx < 64; idx++) begin
      refA[idx] = int'($urandom_range(255)) - 128;
      refB[idx] = ((idx / 8) == (idx % 8)) ? 1 : 0;
    end
    loadMats();
    runTimed(0);
    checkResults("R4 identity placement");
    foreach (refA[a]) begin end
    resAddr = 7'd64;  #1; check(resData == 0, "R4 addr 64 reads zero", int'(resData), 0);
    resAddr = 7'd100; #1; check(resData == 0, "R4 addr 100 reads zero", int'(resData), 0);
    resAddr = 7'd127; #1; check(resData == 0, "R4 addr 127 reads zero", int'(resData), 0);
  endtask

  task automatic t_sticky();
    repeat (20) @(negedge clk);
    check(done == 1'b1, "R6 done stays high", int'(done), 1);
    check(clockCount == 513, "R7 count frozen", int'(clockCount), 513);
  endtask

  task automatic t_busy_start();
    for (int idx = 0; idx < 64; idx++) begin
      refA[idx] = int'($urandom_range(255)) - 128;
      refB[idx] = int'($urandom_range(255)) - 128;
    end
    loadMats();
    runTimed(101);
    checkResults("R8 R1 busy start and load ignored");
  endtask

  task automatic t_relaunch();
    for (int idx = 0; idx < 64; idx++) refB[idx] = int'($urandom_range(255)) - 128;
    loadMats();
    check(done == 1'b1, "R6 done held across loads", int'(done), 1);
    runTimed(0);
    checkResults("R9 relaunch new results");
  endtask

  task automatic t_reset_midrun();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (200) @(negedge clk);
    reset = 1'b1;
    repeat (2) @(negedge clk);
    reset = 1'b0;
    check(!done && clockCount == 0, "R10 reset aborts run", int'(clockCount), 0);
    repeat (600) @(negedge clk);
    check(!done && clockCount == 0, "R10 stays idle after abort", int'(done), 0);
    runTimed(0);
    checkResults("R10 run after abort");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    reset = 1'b0;
    @(negedge clk);
    t_reset();
    t_random();
    t_sticky();
    t_extremes();
    t_identity();
    t_busy_start();
    t_relaunch();
    t_reset_midrun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule